// File: doc/BRIEF.md
# I2C Slave Register-Bank Front End

This block is an I2C-bus slave that gives a bus master access to sixteen byte-wide registers. The slave address is fixed at 7'b1010001. SCL and SDA are sampled with the system clock. START and STOP conditions and SCL edges are found in the system clock domain. The slave pulls SDA low only through an open-drain enable output, and it never drives SDA high. It does not stretch the clock.

A write transfer sends the slave address, then a register-pointer byte, then any number of data bytes. A read transfer sends data starting from the pointer that the slave already holds. A master can set the pointer with a short write, issue a repeated START with the read address, and then read from the new pointer. It can also read at once and continue from where the previous transfer stopped.

A host-side port reads and writes the same registers directly.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits are 1010001. Bit 0 of the address byte selects read (1) or write (0), so the accepted bytes are 0xA2 and 0xA3. For any other address the slave acknowledges nothing and keeps SDA released until the next START.
- R2: SDA is driven open-drain: `sda_oe`=1 pulls the line low and `sda_oe`=0 releases it. `sda_oe` is 0 from reset.
- R3: `sda_oe` changes only on the cycle after a synchronized falling edge of SCL, a START or a STOP.
- R4: Each received byte gets an acknowledge: SDA is held low for the whole ninth clock. This applies to a matching address byte, the pointer byte and every data byte. SDA does not change while SCL is high.
- R5: In a write transfer, the first byte after the address loads the register pointer from its low four bits. The upper four bits are ignored.
- R6: Each later byte of a write transfer is stored in the register the pointer selects. The pointer then increments, wrapping from 15 to 0.
- R7: In a read transfer, the slave sends the register the pointer selects, MSB first, and the pointer increments with wrap after each byte. A read that opens directly with 0xA3 starts from the retained pointer.
- R8: When the master does not acknowledge a byte it has read, the slave releases SDA and keeps it released until the next START.
- R9: A START or STOP inside a byte abandons that byte. No register is written, the pointer keeps its value, and a START begins a new address phase.
- R10: `host_rdata` always shows the register that `host_addr` selects. `host_we` writes `host_wdata` to that register. When a bus write and a host write hit the same register on the same clock, the bus value is stored.
- R11: Reset clears all registers and the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host register index |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register selected by host_addr |

## Verification
The bench sweeps every 7-bit address with the write bit set. A decoder that compared too few bits, or that included the R/W bit, would acknowledge a foreign address or fail to acknowledge its own. Writes and reads run across the 15-to-0 pointer wrap with a pointer byte whose upper nibble is set. A design that kept the upper nibble or forgot the wrap would store to the wrong registers, and that shows up in the host-side readback.

STOP and repeated START are sent part-way through a byte. A design that committed partial bytes or cleared the pointer would then return wrong data on the next direct read. The bench also checks that SDA stays released after a master NACK, because a slave that kept transmitting would pull the line low. It also lands a host write on the same clock as a bus write, where a design with the wrong priority would keep the host value.

// File: rtl/i2c_rb_pkg.sv
// Shared types for the I2C register-bank slave.
package i2c_rb_pkg;

    // Bus-side controller states.
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for a START
        ST_RX,      // shifting in a byte from the master
        ST_RX_ACK,  // slave holds SDA low for the ninth clock
        ST_TX,      // shifting out a byte to the master
        ST_TX_ACK   // sampling the master's acknowledge
    } fsm_t;

    // Meaning of the byte being received.
    typedef enum logic [1:0] {
        KIND_ADDR,
        KIND_PTR,
        KIND_DATA
    } kind_t;

endpackage

// File: rtl/i2c_rb_sync.sv
// Synchronizes SCL and SDA into the system clock domain and flags SCL edges
// and START/STOP conditions, one cycle wide each.
// Assumes the system clock is several times faster than SCL and that the
// idle bus level is high on both lines.
module i2c_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // Synchronizer chains plus one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Edge and condition decode from the synchronized lines.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_rb_regfile.sv
// Register array with a bus write port, a bus read port and a host
// read/write port. The bus write wins when both write one entry at once.
// Reads are combinational.
module i2c_rb_regfile #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_waddr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [AW-1:0] bus_raddr,
    output logic [DW-1:0] bus_rdata,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Storage update with the bus port taking priority per entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (bus_we && bus_waddr == AW'(i))
                    mem[i] <= bus_wdata;
                else if (host_we && host_addr == AW'(i))
                    mem[i] <= host_wdata;
            end
        end
    end

    // Read ports.
    always_comb begin
        bus_rdata  = mem[bus_raddr];
        host_rdata = mem[host_addr];
    end

endmodule

// File: rtl/i2c_rb_ctrl.sv
// Byte-level I2C slave controller: address match, acknowledge, pointer load,
// data write and read with auto-increment.
// Assumes that the inputs are synchronized strobes from i2c_rb_sync and
// that rd_data follows ptr combinationally. Writes leave the block one cycle
// after the byte completes, through wr_en/wr_addr/wr_data.
module i2c_rb_ctrl
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h51,
    parameter int         AW       = 4,
    parameter int         DW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [DW-1:0] rd_data,
    output logic          sda_oe,
    output logic [AW-1:0] ptr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DW);

    fsm_t             state;
    kind_t            kind;
    logic             rw;
    logic             mack;
    logic [CNT_W-1:0] bitcnt;
    logic [DW-1:0]    shreg;

    // Main sequencer; START/STOP override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind    <= KIND_ADDR;
            rw      <= 1'b0;
            mack    <= 1'b0;
            bitcnt  <= '0;
            shreg   <= '0;
            sda_oe  <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state  <= ST_RX;
                kind   <= KIND_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[DW-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == LAST) begin
                            case (kind)
                                KIND_ADDR: begin
                                    if (shreg[DW-1:1] == DEV_ADDR) begin
                                        rw     <= shreg[0];
                                        sda_oe <= 1'b1;
                                        state  <= ST_RX_ACK;
                                    end else begin
                                        state  <= ST_IDLE;
                                    end
                                end
                                KIND_PTR: begin
                                    ptr    <= shreg[AW-1:0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_RX_ACK;
                                end
                                default: begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= shreg;
                                    ptr     <= ptr + 1'b1;
                                    sda_oe  <= 1'b1;
                                    state   <= ST_RX_ACK;
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (kind == KIND_ADDR && rw) begin
                                shreg  <= rd_data;
                                ptr    <= ptr + 1'b1;
                                sda_oe <= ~rd_data[DW-1];
                                state  <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                kind   <= (kind == KIND_ADDR) ? KIND_PTR : KIND_DATA;
                                state  <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bitcnt == LAST) begin
                                sda_oe <= 1'b0;
                                state  <= ST_TX_ACK;
                            end else begin
                                shreg  <= {shreg[DW-2:0], 1'b0};
                                sda_oe <= ~shreg[DW-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                shreg  <= rd_data;
                                ptr    <= ptr + 1'b1;
                                sda_oe <= ~rd_data[DW-1];
                                bitcnt <= '0;
                                state  <= ST_TX;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_regbank_slave.sv
// Top level: I2C slave front end joined to a 16 x 8 register bank with a
// host port. SDA is driven only through the open-drain enable sda_oe.
// Assumes that the system clock runs at least about eight times the SCL rate.
module i2c_regbank_slave #(
    parameter logic [6:0] DEV_ADDR   = 7'h51,
    parameter int         AW         = 4,
    parameter int         DW         = 8,
    parameter int         SYNC_STAGE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata
);
    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [AW-1:0] ptr;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] rd_data;

    i2c_rb_sync #(.STAGES(SYNC_STAGE)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rb_ctrl #(.DEV_ADDR(DEV_ADDR), .AW(AW), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    i2c_rb_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (wr_en),
        .bus_waddr  (wr_addr),
        .bus_wdata  (wr_data),
        .bus_raddr  (ptr),
        .bus_rdata  (rd_data),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

endmodule

// File: rtl/i2c_rb_checker.sv
// Protocol and storage properties of i2c_regbank_slave, bound to the top.
module i2c_rb_checker #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          scl_fall,
    input logic          start_det,
    input logic          stop_det,
    input logic          sda_oe,
    input logic [AW-1:0] ptr,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          host_we,
    input logic [AW-1:0] host_addr,
    input logic [DW-1:0] host_rdata
);
    // R3: the drive enable moves only after an SCL fall or a bus condition.
    assert_oe_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    // R4: SDA is steady while SCL stays high.
    assert_oe_steady_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R6: a bus write leaves the pointer one past the written register.
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (ptr == AW'(wr_addr + 1'b1)));

    // R8: after a STOP the line is released.
    assert_release_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_oe);

    // R10: on a same-register collision the bus value is stored.
    assert_bus_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en && host_we && wr_addr == host_addr) && $stable(host_addr))
        |-> (host_rdata == $past(wr_data)));

endmodule

bind i2c_regbank_slave i2c_rb_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_oe     (sda_oe),
    .ptr        (ptr),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_rdata (host_rdata)
);

// File: tb/tb_i2c_regbank_slave.sv
module tb_i2c_regbank_slave;
    localparam int Q = 6; // quarter SCL period in system clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_oe;
    logic       host_we = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       sda_line;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] ref_mem [16];
    logic [3:0] ref_ptr = '0;

    always #4 clk = ~clk;
    assign sda_line = ~(sda_oe | m_low);

    i2c_regbank_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe(sda_oe), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        m_low = 1'b0; wq; scl_drv = 1'b1; wq; m_low = 1'b1; wq; scl_drv = 1'b0; wq;
    endtask

    task automatic bus_stop;
        m_low = 1'b1; wq; scl_drv = 1'b1; wq; m_low = 1'b0; wq;
    endtask

    task automatic put_bit(input logic b);
        m_low = ~b; wq; scl_drv = 1'b1; wq; wq; scl_drv = 1'b0; wq;
    endtask

    task automatic get_bit(output logic b);
        m_low = 1'b0; wq; scl_drv = 1'b1; wq; b = sda_line; wq; scl_drv = 1'b0; wq;
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~give_ack);
    endtask

    task automatic check_all_regs(input string req);
        for (int i = 0; i < 16; i++) begin
            host_addr = 4'(i);
            @(negedge clk);
            chk(req, host_rdata, ref_mem[i]);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic       ack;
        logic       b;
        logic [7:0] d;
        for (int i = 0; i < 16; i++) ref_mem[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R11: reset state
        chk("R2 reset oe", sda_oe, 0);
        check_all_regs("R11 reset regs");

        // R1: sweep all 7-bit addresses, write direction
        for (int a = 0; a < 128; a++) begin
            bus_start;
            put_byte({7'(a), 1'b0}, ack);
            chk("R1 address ack", ack, (a == 7'h51) ? 1 : 0);
            put_byte(8'h00, ack);
            chk("R1 follow-on byte ack", ack, (a == 7'h51) ? 1 : 0);
            bus_stop;
        end
        bus_start;
        put_byte(8'hA5, ack);
        chk("R1 foreign read address", ack, 0);
        get_bit(b);
        chk("R1 foreign released", b, 1);
        bus_stop;

        // R4 / R5 / R6: pointer with upper nibble set, 16 bytes across the wrap
        bus_start;
        put_byte(8'hA2, ack); chk("R4 address ack", ack, 1);
        put_byte(8'hF3, ack); chk("R4 R5 pointer ack", ack, 1);
        ref_ptr = 4'h3;
        for (int i = 0; i < 16; i++) begin
            d = 8'((i * 37 + 5) & 8'hFF);
            put_byte(d, ack);
            chk("R4 data ack", ack, 1);
            ref_mem[ref_ptr] = d;
            ref_ptr = ref_ptr + 1'b1;
        end
        bus_stop;
        check_all_regs("R5 R6 written regs");

        // R7: set pointer, repeated START, read 20 bytes across the wrap
        bus_start;
        put_byte(8'hA2, ack);
        put_byte(8'h0E, ack);
        ref_ptr = 4'hE;
        bus_start;
        put_byte(8'hA3, ack); chk("R7 read address ack", ack, 1);
        for (int i = 0; i < 20; i++) begin
            get_byte(i != 19, d);
            chk("R7 read after pointer", d, ref_mem[ref_ptr]);
            ref_ptr = ref_ptr + 1'b1;
        end
        bus_stop;

        // R7 / R8: direct read from retained pointer, NACK on last byte
        bus_start;
        put_byte(8'hA3, ack);
        for (int i = 0; i < 3; i++) begin
            get_byte(i != 2, d);
            chk("R7 direct read", d, ref_mem[ref_ptr]);
            ref_ptr = ref_ptr + 1'b1;
        end
        wq;
        chk("R8 released after nack", sda_oe, 0);
        get_bit(b);
        chk("R8 extra clock reads high", b, 1);
        get_bit(b);
        chk("R8 still released", b, 1);
        bus_stop;

        // R9: STOP in the middle of a data byte
        bus_start;
        put_byte(8'hA2, ack);
        put_byte(8'h09, ack);
        ref_ptr = 4'h9;
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_stop;
        check_all_regs("R9 no write on abort");
        bus_start;
        put_byte(8'hA3, ack);
        get_byte(1'b0, d);
        chk("R9 pointer kept after stop", d, ref_mem[ref_ptr]);
        ref_ptr = ref_ptr + 1'b1;
        bus_stop;

        // R9: repeated START in the middle of the pointer byte
        bus_start;
        put_byte(8'hA2, ack);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_start;
        put_byte(8'hA3, ack);
        chk("R9 ack after restart", ack, 1);
        get_byte(1'b0, d);
        chk("R9 pointer kept after restart", d, ref_mem[ref_ptr]);
        ref_ptr = ref_ptr + 1'b1;
        bus_stop;

        // R10: host write then bus read
        host_addr = 4'h6; host_wdata = 8'hC3; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        ref_mem[6] = 8'hC3;
        chk("R10 host readback", host_rdata, 8'hC3);
        bus_start;
        put_byte(8'hA2, ack);
        put_byte(8'h06, ack);
        bus_start;
        put_byte(8'hA3, ack);
        get_byte(1'b0, d);
        chk("R10 host write seen on bus", d, 8'hC3);
        bus_stop;

        // R10: collision, bus wins
        bus_start;
        put_byte(8'hA2, ack);
        put_byte(8'h06, ack);
        fork
            put_byte(8'h5A, ack);
            begin
                host_addr = 4'h6; host_wdata = 8'hEE; host_we = 1'b1;
                @(negedge clk iff sda_oe);
                @(negedge clk);
                host_we = 1'b0;
            end
        join
        bus_stop;
        ref_mem[6] = 8'h5A;
        host_addr = 4'h6;
        @(negedge clk);
        chk("R10 bus wins collision", host_rdata, 8'h5A);
        check_all_regs("R10 final regs");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule